// File: doc/BRIEF.md
# Distributed Bus Arbitration Contender

This block is the arbitration agent that sits on each card of a multi-master synchronous bus. No central arbiter exists. Every card that wants the bus pulls a shared open-collector request line low and drives its own 4-bit contender code, which is the card's slot identity, onto four shared open-collector, active-low arbitration lines. Each line reads as the OR of the code bits that the cards drive onto it. Each contender compares its code with what the lines show. When it sees that another card holds a 1 in a bit position where its own code has a 0, it withdraws from every lower bit. The lines settle on the highest code among the contenders, and that card is told it owns the bus.

A card joins a contest only when the request line is fully released. The owner holds its request and its code on the lines for as long as its local master keeps the request up. The other contenders stay in the contest. When the owner lets go, the remaining contenders resolve again without any new card joining. A card that has just owned the bus therefore cannot win again until every card that was waiting has had its turn. The block has a synchronous active-high reset. While reset is high, the open-drain drive enables are forced off at once.

Top module: `arb_contender`

## Requirements
- R1: While `rst` is high, `arb_drv_o`, `rqst_drv_o` and `won_o` are all 0 in the same cycle, whatever state the block was in. After reset the block is idle.
- R2: An idle card with `req_i` high starts contending, which means asserting `rqst_drv_o`, only at a clock edge where it samples `rqst_n_i` = 1 (line released). Otherwise it keeps waiting.
- R3: When it starts contending, the card raises `rqst_drv_o` and sets `arb_drv_o[i]` = 1 (pull line i low) for every bit i where `slot_id_i[i]` = 1. It never pulls a line whose code bit is 0.
- R4: The card contends with code value `~arb_n_i`. If a bit exists where its own code is 0 and that value is 1, then at the next edge the card stops driving every line below that bit.
- R5: The card declares `won_o` after two consecutive edges at which `~arb_n_i` equals its own code. A card contending alone raises `rqst_drv_o` one edge after `req_i` is seen and raises `won_o` two edges after that.
- R6: Among the cards contending together, the one with the numerically highest code wins. While it owns the bus, `~arb_n_i` equals its code.
- R7: At most one card has `won_o` high at any time.
- R8: While it owns the bus, a card keeps `rqst_drv_o` high and drives its full code. The edge after `req_i` falls clears `won_o`, `rqst_drv_o` and `arb_drv_o`.
- R9: Within one contest, each card wins once, in descending code order. A previous owner that requests again wins only after the request line has been released by all cards.
- R10: A contender whose `req_i` falls before it has won releases all of its drives at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset; gates all drives off while high |
| req_i | input | 1 | Local master wants (or keeps) the bus |
| slot_id_i | input | CODE_W | Slot identity used as contender code |
| arb_n_i | input | CODE_W | Sampled level of the shared arbitration lines (low = asserted) |
| rqst_n_i | input | 1 | Sampled level of the shared request line (low = asserted) |
| arb_drv_o | output | CODE_W | Open-drain enables; bit i = 1 pulls arbitration line i low |
| rqst_drv_o | output | 1 | Open-drain enable for the request line |
| won_o | output | 1 | This card owns the bus |

## Verification
The case that is hardest to reach is a previous owner asking again while other cards are still queued behind it. Reaching it needs several cards that resolve against each other through shared wired lines, with one of them re-requesting the cycle after it lets go. The bench builds four contenders that share modelled wired-AND lines. A service loop releases each winner after a few cycles of ownership and immediately re-raises the request of the first owner. The scoreboard then expects that card last. Separate tests cover code subsets such as 0001 against 0011, the all-zero code, a 0111 contender that must back off against 1000, and a contender that withdraws before it wins.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_OWN  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/arb_backoff.sv
// Per-bit back-off: a bit stays driven only if no higher bit shows 1 on
// the lines where the own code holds 0.
module arb_backoff #(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] own_i,
  input  logic [CODE_W-1:0] bus_i,
  output logic [CODE_W-1:0] drv_o,
  output logic              match_o
);
  // kill[i]: some bit at position >= i outranks this card
  logic [CODE_W:1] kill;

  assign kill[CODE_W] = 1'b0;

  genvar gi;
  generate
    for (gi = CODE_W - 1; gi >= 1; gi--) begin : g_kill
      assign kill[gi] = kill[gi+1] | (~own_i[gi] & bus_i[gi]);
    end
    for (gi = 0; gi < CODE_W; gi++) begin : g_drv
      assign drv_o[gi] = own_i[gi] & ~kill[gi+1];
    end
  endgenerate

  assign match_o = (own_i == bus_i);
endmodule

// File: rtl/arb_settle.sv
// Counts consecutive samples on which the lines equal the own code.
module arb_settle #(
  parameter int SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hit,
  output logic done_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (hit) begin
      if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign done_o = hit && (cnt_q == LAST) && !clr;
endmodule

// File: rtl/arb_contender.sv
module arb_contender #(
  parameter int CODE_W     = 4,
  parameter int SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [CODE_W-1:0] slot_id_i,
  input  logic [CODE_W-1:0] arb_n_i,
  input  logic              rqst_n_i,
  output logic [CODE_W-1:0] arb_drv_o,
  output logic              rqst_drv_o,
  output logic              won_o
);
  import arb_pkg::*;

  arb_state_e        state_q;
  logic [CODE_W-1:0] drv_q;
  logic              rq_q;
  logic              won_q;

  logic [CODE_W-1:0] bus_code;
  logic [CODE_W-1:0] bo_drv;
  logic              bus_match;
  logic              settled;

  assign bus_code = ~arb_n_i;

  arb_backoff #(.CODE_W(CODE_W)) u_backoff (
    .own_i   (slot_id_i),
    .bus_i   (bus_code),
    .drv_o   (bo_drv),
    .match_o (bus_match)
  );

  arb_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .clr    (state_q != ST_ARB),
    .hit    (bus_match),
    .done_o (settled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      drv_q   <= '0;
      rq_q    <= 1'b0;
      won_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_i && rqst_n_i) begin
            state_q <= ST_ARB;
            rq_q    <= 1'b1;
            drv_q   <= slot_id_i;
          end
        end
        ST_ARB: begin
          if (!req_i) begin
            state_q <= ST_IDLE;
            rq_q    <= 1'b0;
            drv_q   <= '0;
          end else if (settled) begin
            state_q <= ST_OWN;
            won_q   <= 1'b1;
            drv_q   <= bo_drv;
          end else begin
            drv_q   <= bo_drv;
          end
        end
        ST_OWN: begin
          if (!req_i) begin
            state_q <= ST_IDLE;
            rq_q    <= 1'b0;
            drv_q   <= '0;
            won_q   <= 1'b0;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          rq_q    <= 1'b0;
          drv_q   <= '0;
          won_q   <= 1'b0;
        end
      endcase
    end
  end

  // reset releases the open-drain enables in the same cycle
  assign arb_drv_o  = drv_q & {CODE_W{~rst}};
  assign rqst_drv_o = rq_q & ~rst;
  assign won_o      = won_q & ~rst;
endmodule

// File: rtl/arb_contender_chk.sv
module arb_contender_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_i,
  input logic [CODE_W-1:0] slot_id_i,
  input logic [CODE_W-1:0] arb_n_i,
  input logic              rqst_n_i,
  input logic [CODE_W-1:0] arb_drv_o,
  input logic              rqst_drv_o,
  input logic              won_o
);
  always @(posedge clk) begin
    if (rst) begin
      assert_reset_release_R1: assert (arb_drv_o == '0 && !rqst_drv_o && !won_o)
        else $error("drive active during reset");
    end
  end

  always @(posedge clk) begin
    assert_no_zero_bit_drive_R3: assert ((arb_drv_o & ~slot_id_i) == '0)
      else $error("line driven for a 0 code bit");
  end

  assert_join_released_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(rqst_drv_o) |-> ($past(rqst_n_i) && $past(req_i)));

  assert_owner_full_code_R5: assert property (@(posedge clk) disable iff (rst)
    won_o |-> (rqst_drv_o && arb_drv_o == slot_id_i));

  assert_lines_show_owner_R6: assert property (@(posedge clk) disable iff (rst)
    won_o |-> (~arb_n_i == slot_id_i));

  assert_own_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
    won_o |-> $past(req_i));

  assert_release_all_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(won_o) |-> (arb_drv_o == '0 && !rqst_drv_o));
endmodule

bind arb_contender arb_contender_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_i      (req_i),
  .slot_id_i  (slot_id_i),
  .arb_n_i    (arb_n_i),
  .rqst_n_i   (rqst_n_i),
  .arb_drv_o  (arb_drv_o),
  .rqst_drv_o (rqst_drv_o),
  .won_o      (won_o)
);

// File: tb/test_arb_contender.sv
module test_arb_contender;
  localparam int NCARD = 4;
  localparam int CW    = 4;
  localparam int HOLD  = 3;
  localparam int WDOG  = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCARD-1:0] req = '0;
  logic [CW-1:0] ids [NCARD];
  logic [CW-1:0] drv [NCARD];
  logic [NCARD-1:0] rqd;
  logic [NCARD-1:0] won;
  logic [CW-1:0] acc;
  logic [CW-1:0] arb_n;
  logic rqst_n;

  always #5 clk = ~clk;

  // wired-AND of the open-collector lines
  always_comb begin
    acc = '0;
    for (int k = 0; k < NCARD; k++) acc = acc | drv[k];
  end
  assign arb_n  = ~acc;
  assign rqst_n = ~(|rqd);

  genvar gk;
  generate
    for (gk = 0; gk < NCARD; gk++) begin : g_card
      arb_contender #(.CODE_W(CW), .SETTLE_CYC(2)) i_arb_contender (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req[gk]),
        .slot_id_i  (ids[gk]),
        .arb_n_i    (arb_n),
        .rqst_n_i   (rqst_n),
        .arb_drv_o  (drv[gk]),
        .rqst_drv_o (rqd[gk]),
        .won_o      (won[gk])
      );
    end
  endgenerate

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int exp_q [$];
  logic [NCARD-1:0] won_prev = '0;
  bit auto_srv = 0;
  int own_cnt [NCARD];
  int rereq [NCARD];
  bit pend [NCARD];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // one cycle: scoreboard monitor plus the ownership servicer
  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > WDOG) begin
      chk(0, "watchdog", cyc, WDOG);
      finish_run();
    end
    for (int k = 0; k < NCARD; k++) begin
      if (won[k] && !won_prev[k]) begin
        chk($countones(won) == 1, "R7 single owner", $countones(won), 1);
        if (exp_q.size() == 0) begin
          chk(0, "R6 unexpected winner", int'(ids[k]), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(ids[k]) == e, "R6/R9 winner order", int'(ids[k]), e);
        end
      end
    end
    won_prev = won;
    if (auto_srv) begin
      for (int k = 0; k < NCARD; k++) begin
        if (pend[k]) begin
          req[k]  = 1'b1;
          pend[k] = 0;
        end else if (won[k]) begin
          own_cnt[k]++;
          if (own_cnt[k] == HOLD) begin
            req[k]     = 1'b0;
            own_cnt[k] = 0;
            if (rereq[k] > 0) begin
              rereq[k]--;
              pend[k] = 1;
            end
          end
        end
      end
    end
  endtask

  task automatic wait_won(input int k, input string tag);
    int t;
    t = 0;
    while (!won[k] && t < 50) begin
      step();
      t++;
    end
    chk(won[k], tag, int'(won[k]), 1);
  endtask

  task automatic run_round(input string tag);
    int t;
    t = 0;
    auto_srv = 1;
    while ((exp_q.size() != 0 || won != '0 || req != '0) && t < 400) begin
      step();
      t++;
    end
    auto_srv = 0;
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    for (int k = 0; k < NCARD; k++) begin
      ids[k] = CW'(k);
      own_cnt[k] = 0;
      rereq[k] = 0;
      pend[k] = 0;
    end
    // R1: reset state
    step();
    step();
    for (int k = 0; k < NCARD; k++)
      chk(drv[k] == '0 && !rqd[k] && !won[k], "R1 reset idle", int'(drv[k]), 0);
    rst = 1'b0;
    step();

    // R3/R5/R8: lone contender, id 6
    ids[0] = 4'd6;
    exp_q.push_back(6);
    req[0] = 1'b1;
    step();
    chk(rqd[0] == 1'b1, "R3 request driven", int'(rqd[0]), 1);
    chk(drv[0] == 4'd6, "R3 full code driven", int'(drv[0]), 6);
    chk(won[0] == 1'b0, "R5 not yet won", int'(won[0]), 0);
    step();
    chk(won[0] == 1'b0, "R5 still settling", int'(won[0]), 0);
    step();
    chk(won[0] == 1'b1, "R5 won two edges after entry", int'(won[0]), 1);
    req[0] = 1'b0;
    step();
    chk(!won[0] && drv[0] == '0 && !rqd[0], "R8 release on drop", int'(drv[0]), 0);
    step();

    // R2: a newcomer waits while the request line is held
    exp_q.push_back(6);
    exp_q.push_back(9);
    req[0] = 1'b1;
    wait_won(0, "R5 first owner");
    ids[1] = 4'd9;
    req[1] = 1'b1;
    step();
    step();
    step();
    chk(rqd[1] == 1'b0, "R2 newcomer held off", int'(rqd[1]), 0);
    chk(won[0] == 1'b1, "R8 owner keeps bus", int'(won[0]), 1);
    req[0] = 1'b0;
    wait_won(1, "R2 newcomer wins after release");
    chk(~arb_n == 4'd9, "R6 lines show owner", int'(~arb_n), 9);
    req[1] = 1'b0;
    step();
    step();

    // R4/R10: 0111 against 1000, loser withdraws
    ids[0] = 4'd7;
    ids[1] = 4'd8;
    exp_q.push_back(8);
    req[0] = 1'b1;
    req[1] = 1'b1;
    step();
    chk(drv[0] == 4'd7, "R3 entry code 7", int'(drv[0]), 7);
    step();
    chk(drv[0] == 4'd0, "R4 backoff below bit 3", int'(drv[0]), 0);
    chk(drv[1] == 4'd8, "R4 higher keeps code", int'(drv[1]), 8);
    req[0] = 1'b0;
    step();
    chk(!rqd[0] && drv[0] == '0, "R10 withdraw releases", int'(rqd[0]), 0);
    step();
    chk(won[1] == 1'b1, "R5 winner after contest", int'(won[1]), 1);
    req[1] = 1'b0;
    step();
    step();

    // R9/R6: full contest, first owner re-requests at once
    ids[0] = 4'd12; ids[1] = 4'd5; ids[2] = 4'd10; ids[3] = 4'd3;
    exp_q.push_back(12); exp_q.push_back(10); exp_q.push_back(5);
    exp_q.push_back(3);  exp_q.push_back(12);
    rereq[0] = 1;
    req = '1;
    run_round("R9 fair round complete");
    step();

    // R6: subset codes and the zero code
    ids[0] = 4'd1; ids[1] = 4'd3; ids[2] = 4'd0; ids[3] = 4'd2;
    exp_q.push_back(3); exp_q.push_back(2); exp_q.push_back(1); exp_q.push_back(0);
    req = '1;
    run_round("R6 subset round complete");
    step();

    // R1: reset while owning
    ids[2] = 4'd5;
    exp_q.push_back(5);
    req[2] = 1'b1;
    wait_won(2, "R5 owner before reset");
    rst = 1'b1;
    #1;
    chk(drv[2] == '0 && !rqd[2] && !won[2], "R1 immediate release", int'(drv[2]), 0);
    req[2] = 1'b0;
    step();
    rst = 1'b0;
    step();
    chk(won == '0 && rqd == '0, "R1 idle after reset", int'(won), 0);

    finish_run();
  end
endmodule